// File: doc/BRIEF.md
# Guarded Flash Erase Command Controller

This block sits between a register write bus and a flash array. It starts an erase cycle only after a guarded sequence of writes. A write to the page register latches a 7-bit page number and arms a page erase. A write of 1 to the mass-enable register arms a mass erase. A later write of an exact key byte to the command register then starts the armed cycle.

Each arming write covers one cycle only. It is used up when its erase is issued, so it must be written again before the next erase. A mass erase also needs the debug-port-enabled input to be high when the key arrives. A command that does not qualify is dropped without any report, and it leaves the existing arming state as it was.

The flash reports its progress through a busy level and a done pulse. Command writes are ignored while the flash is busy, and also while an issued erase is still waiting for its done pulse.

Top module: `flash_erase_guard`

## Requirements
- R1: After reset, `erase_req`, `erase_mass` and `erase_active` are 0, `erase_page` is 0, and neither erase type is armed.
- R2: Writing any value to address 0 arms a page erase and latches bits [6:0] as the page (0 to 127). A later write of 0x55 to address 2 makes `erase_req` high for exactly one cycle, in the cycle after the write edge. In that cycle `erase_mass` is 0 and `erase_page` holds the latched page.
- R3: An issued page erase uses up the page arming. A second 0x55 with no new write to address 0 issues nothing.
- R4: Writing 1 in bit 0 to address 1 arms a mass erase. A later write of 0xAA to address 2 while `dbg_en` is high makes `erase_req` pulse with `erase_mass` = 1, and the mass arming is then used up.
- R5: A 0xAA command while `dbg_en` is low issues nothing and keeps the mass arming.
- R6: A command byte other than 0x55 or 0xAA, or a key whose erase type is not armed, issues nothing and keeps all arming state.
- R7: Command writes arriving while `flash_busy` is high, or while `erase_active` is high, are ignored. Arming state is kept through them, and arming writes are still accepted.
- R8: `erase_active` rises in the same cycle as `erase_req` and falls in the cycle after `flash_done` is sampled high.
- R9: Writing 0 in bit 0 to address 1 removes a pending mass arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 page, 1 mass enable, 2 command |
| wr_data | input | 8 | Write data |
| dbg_en | input | 1 | Debug port enabled |
| flash_busy | input | 1 | Flash is busy |
| flash_done | input | 1 | Flash erase finished (pulse) |
| erase_req | output | 1 | One-cycle erase start |
| erase_mass | output | 1 | 1 mass erase, 0 page erase |
| erase_page | output | 7 | Page to erase |
| erase_active | output | 1 | Issued erase awaiting done |

## Verification
The assertions check every cycle that each request is a single-cycle pulse, follows a matching key write, and is never issued while busy. They also check that a mass request saw the debug port enabled, and that the page output carries the latched page. Other behaviour can only be shown by the bench's scenarios against its reference model. That covers arming being used up and kept, foreign bytes having no effect, a zero write disarming mass erase, and commands being dropped while waiting for done.

// File: rtl/flash_erase_guard.sv
module flash_erase_guard #(
  parameter int          PAGE_W   = 7,
  parameter logic [7:0]  PAGE_KEY = 8'h55,
  parameter logic [7:0]  MASS_KEY = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              dbg_en,
  input  logic              flash_busy,
  input  logic              flash_done,
  output logic              erase_req,
  output logic              erase_mass,
  output logic [PAGE_W-1:0] erase_page,
  output logic              erase_active
);
  localparam logic [1:0] A_PAGE = 2'd0;
  localparam logic [1:0] A_MASS = 2'd1;
  localparam logic [1:0] A_CMD  = 2'd2;

  logic [PAGE_W-1:0] page_q;
  logic page_armed, mass_armed;

  wire cmd_ok  = wr_en && wr_addr == A_CMD && !flash_busy && !erase_active;
  wire go_page = cmd_ok && wr_data == PAGE_KEY && page_armed;
  wire go_mass = cmd_ok && wr_data == MASS_KEY && mass_armed && dbg_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q       <= '0;
      page_armed   <= 1'b0;
      mass_armed   <= 1'b0;
      erase_req    <= 1'b0;
      erase_mass   <= 1'b0;
      erase_page   <= '0;
      erase_active <= 1'b0;
    end else begin
      erase_req <= 1'b0;
      if (flash_done) erase_active <= 1'b0;
      if (wr_en && wr_addr == A_PAGE) begin
        page_q     <= wr_data[PAGE_W-1:0];
        page_armed <= 1'b1;
      end
      if (wr_en && wr_addr == A_MASS) mass_armed <= wr_data[0];
      if (go_page || go_mass) begin
        erase_req    <= 1'b1;
        erase_mass   <= go_mass;
        erase_page   <= page_q;
        erase_active <= 1'b1;
      end
      if (go_page) page_armed <= 1'b0;
      if (go_mass) mass_armed <= 1'b0;
    end
  end

  // R2: request is a single-cycle pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req);
  // R2: page request follows a page key write and carries the latched page
  a_r2_page_key: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && !erase_mass) |-> $past(wr_en && wr_addr == A_CMD && wr_data == PAGE_KEY));
  a_r2_page_value: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> erase_page == $past(page_q));
  // R4 / R5: mass request needs its key and the debug port
  a_r4_mass_needs_debug: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && erase_mass) |-> $past(dbg_en && wr_data == MASS_KEY));
  // R7: nothing issued while the flash is busy
  a_r7_not_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> !$past(flash_busy) && !$past(erase_active));
  // R8: active accompanies every request
  a_r8_active_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> erase_active);
endmodule

// File: tb/flash_erase_guard_bench.sv
module flash_erase_guard_bench;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, dbg_en = 0, flash_busy = 0, flash_done = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic erase_req, erase_mass, erase_active;
  logic [6:0] erase_page;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flash_erase_guard u_flash_erase_guard (.*);

  // behavioural reference model
  bit m_req, m_mass, m_act, m_parm, m_marm;
  int m_page, m_lat;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_req = 0; m_mass = 0; m_act = 0; m_parm = 0; m_marm = 0; m_page = 0; m_lat = 0;
    end else begin
      bit ok, gp, gm;
      ok = wr_en && wr_addr == 2 && !flash_busy && !m_act;
      gp = ok && wr_data == 8'h55 && m_parm;
      gm = ok && wr_data == 8'hAA && m_marm && dbg_en;
      m_req = 0;
      if (flash_done) m_act = 0;
      if (gp || gm) begin
        m_req = 1; m_mass = gm; m_page = m_lat; m_act = 1;
        if (gp) m_parm = 0;
        if (gm) m_marm = 0;
      end
      if (wr_en && wr_addr == 0) begin m_lat = wr_data[6:0]; m_parm = 1; end
      if (wr_en && wr_addr == 1) m_marm = wr_data[0];
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    n_chk++;
    if ({erase_req, erase_mass, erase_page, erase_active} !== {m_req, m_mass, 7'(m_page), m_act}) begin
      n_bad++;
      $display("FAIL model R2 R4 R8: got req=%0b mass=%0b page=%0d act=%0b exp %0b %0b %0d %0b",
               erase_req, erase_mass, erase_page, erase_active, m_req, m_mass, m_page, m_act);
    end
  end

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1 wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); #1 wr_en = 0;
  endtask

  task automatic done_pulse();
    @(negedge clk); #1 flash_done = 1;
    @(negedge clk); #1 flash_done = 0;
  endtask

  task automatic expect_req(input bit exp, input string tag);
    chk(erase_req == exp, tag, erase_req, exp);
  endtask

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(erase_req == 0 && erase_active == 0 && erase_page == 0 && erase_mass == 0, "R1 reset", erase_req, 0);
    #1 rst_n = 1;
    @(negedge clk);
    wr(2, 8'h55); expect_req(0, "R1 no page arm after reset");
    dbg_en = 1;
    wr(2, 8'hAA); expect_req(0, "R1 no mass arm after reset");

    wr(0, 8'h85); wr(2, 8'h55);
    expect_req(1, "R2 page req");
    chk(erase_page == 5 && erase_mass == 0, "R2 page value", erase_page, 5);
    chk(erase_active == 1, "R8 active rises", erase_active, 1);
    @(negedge clk); expect_req(0, "R2 one-cycle pulse");
    done_pulse(); chk(erase_active == 0, "R8 active falls", erase_active, 0);

    wr(2, 8'h55); expect_req(0, "R3 page arm used up");

    dbg_en = 0; wr(1, 8'h01); wr(2, 8'hAA); expect_req(0, "R5 debug disabled");
    dbg_en = 1; wr(2, 8'hAA);
    expect_req(1, "R5 mass arm kept");
    chk(erase_mass == 1, "R4 mass type", erase_mass, 1);
    done_pulse();
    wr(2, 8'hAA); expect_req(0, "R4 mass arm used up");

    wr(0, 8'h7F); wr(2, 8'h12); expect_req(0, "R6 foreign byte");
    wr(2, 8'hAA); expect_req(0, "R6 unarmed key");
    wr(2, 8'h55); expect_req(1, "R6 arming kept");
    chk(erase_page == 127, "R6 page 127", erase_page, 127);
    done_pulse();

    wr(0, 8'h03); flash_busy = 1; wr(2, 8'h55); expect_req(0, "R7 busy ignored");
    flash_busy = 0; wr(2, 8'h55); expect_req(1, "R7 arming kept through busy");
    chk(erase_page == 3, "R7 page 3", erase_page, 3);
    wr(0, 8'h09); wr(2, 8'h55); expect_req(0, "R7 ignored while active");
    done_pulse(); wr(2, 8'h55); expect_req(1, "R7 arm write taken while active");
    chk(erase_page == 9, "R7 page 9", erase_page, 9);
    done_pulse();

    wr(1, 8'h01); wr(1, 8'h00); wr(2, 8'hAA); expect_req(0, "R9 zero disarms");

    repeat (3) @(negedge clk);
    summary();
  end
endmodule